// File: doc/BRIEF.md
# Dual-Requester AXI4 Read Bridge

This block lets two independent clients, a compute-core port and a controller port, share one AXI4 read channel. Each client asks for a read by placing a 32-bit word address on its address input and pulsing its request line for a single cycle. The bridge latches the request, picks one pending request in fixed priority, and drives a single-beat AXI4 read. Only one read is in flight at any time. The 32-bit client address is widened to the 48-bit physical address of the bus by filling the upper 16 bits with zeros.

When the R beat arrives, the returned word is written into the owning client's data register. That client's acknowledge pulses for one cycle. The data register then holds its value until the next read completes for the same client, so a client may sample the data on the acknowledge cycle or on any later cycle. The core port wins when both clients request on the same cycle. The controller request stays latched and is issued once the core read has finished.

Top module: `dual_rd_bridge`

## Requirements
- R1: While rst_n is low at a rising clock edge, the block clears ar_valid, ar_addr, r_ready, both acknowledges, both data registers and any latched requests. After reset, no read is issued until a new request pulse arrives.
- R2: On every cycle ar_valid is high, ar_addr[47:32] is zero and ar_addr[31:0] equals the requested client address exactly, including addresses with bit 31 set such as 0x8000_0000.
- R3: With the bridge idle, a one-cycle core_req pulse sampled at clock edge E makes ar_valid high from edge E+1 onward. The pulse is remembered after core_req falls.
- R4: If both requests are sampled at the same edge, the core address is issued first. The controller read is issued on the second edge after the core R beat is accepted.
- R5: A ctl_req pulse with the core port idle is issued with the same two-edge latency as R3, without waiting for anything.
- R6: ar_valid and ar_addr hold their values until the edge at which ar_ready is high. ar_valid falls at that edge.
- R7: Whenever ar_valid is high, ar_len is 0 (one beat) and ar_size is 3'b010 (four bytes).
- R8: r_ready is high exactly from the edge after the address handshake until the edge at which r_valid is sampled high. ar_valid is never high while r_ready is high, so at most one read is outstanding. r_valid and r_data have no effect while r_ready is low.
- R9: After the R beat is accepted at edge E, only the owning port's acknowledge is high, for exactly the one cycle after edge E. An acknowledge never pulses on a port that has no read in flight.
- R10: At an acknowledge, that port's data output equals the r_data of the accepted beat. The data output keeps that value until the port's next acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| core_req | input | 1 | Core read request, one-cycle pulse |
| core_addr | input | 32 | Core word address, sampled with core_req |
| core_ack | output | 1 | Core read complete, one-cycle pulse |
| core_rdata | output | 32 | Core read data, held until next core completion |
| ctl_req | input | 1 | Controller read request, one-cycle pulse |
| ctl_addr | input | 32 | Controller word address, sampled with ctl_req |
| ctl_ack | output | 1 | Controller read complete, one-cycle pulse |
| ctl_rdata | output | 32 | Controller read data, held until next controller completion |
| ar_valid | output | 1 | AXI4 read address valid |
| ar_ready | input | 1 | AXI4 read address ready |
| ar_addr | output | 48 | AXI4 read address, zero-extended |
| ar_len | output | 8 | AXI4 burst length, always 0 |
| ar_size | output | 3 | AXI4 beat size, always four bytes |
| r_valid | input | 1 | AXI4 read data valid |
| r_ready | output | 1 | AXI4 read data ready |
| r_data | input | 32 | AXI4 read data |

## Verification
The assertions take for granted that a client raises no new request while its earlier request is still pending or in flight. They also assume the bus slave asserts r_valid only while r_ready is high, as a single-beat AXI4 slave does. The stimulus keeps to both. It tracks a busy flag per client, which is set on a request and cleared on that client's acknowledge. Its slave model raises r_valid only in the data phase. Outside the data phase it drives random r_data, and random ar_ready whenever no address is offered, to show those inputs are ignored.

// File: rtl/dual_rd_bridge_pkg.sv
// Shared widths and the read-engine state encoding for the dual-requester read bridge.
package dual_rd_bridge_pkg;
    localparam int CLIENT_AW = 32;
    localparam int PHYS_AW   = 48;
    localparam int DATA_W    = 32;
    localparam int NUM_PORTS = 2;

    typedef enum logic [1:0] {
        RD_IDLE = 2'd0,
        RD_ADDR = 2'd1,
        RD_DATA = 2'd2
    } rd_state_t;
endpackage

// File: rtl/rb_req_latch.sv
// Request latch for one client.
// Captures a one-cycle request pulse and its address, and holds both until the arbiter takes the request.
// Assumes the client does not pulse again while its request is pending.
module rb_req_latch #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic [AW-1:0] addr,
    input  logic          take,
    output logic          pend,
    output logic [AW-1:0] addr_q
);
    // Pending flag: set by a pulse, cleared when granted.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend <= 1'b0;
        else if (req)
            pend <= 1'b1;
        else if (take)
            pend <= 1'b0;
    end

    // Address register: loaded together with the pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)
            addr_q <= '0;
        else if (req)
            addr_q <= addr;
    end
endmodule

// File: rtl/rb_arbiter.sv
// Fixed-priority arbiter over the latched requests. Port 0 has the highest priority.
// A grant is given only while the read engine is idle, which gives one read in flight at a time.
// It puts the winning address on the shared address net.
module rb_arbiter #(
    parameter int N  = 2,
    parameter int AW = 32,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]         pend,
    input  logic [N-1:0][AW-1:0] addrs,
    input  logic                 idle,
    output logic                 gnt_valid,
    output logic [IW-1:0]        gnt_idx,
    output logic [N-1:0]         gnt_vec,
    output logic [AW-1:0]        gnt_addr
);
    logic          found;
    logic [IW-1:0] pick;

    // Priority search: the lowest-numbered pending port wins.
    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int i = 0; i < N; i++) begin
            if (!found && pend[i]) begin
                found = 1'b1;
                pick  = IW'(i);
            end
        end
    end

    assign gnt_valid = found && idle;
    assign gnt_idx   = pick;
    assign gnt_addr  = addrs[pick];

    // One-hot grant for clearing the winning latch.
    generate
        for (genvar g = 0; g < N; g++) begin : g_gnt
            assign gnt_vec[g] = gnt_valid && (pick == IW'(g));
        end
    endgenerate
endmodule

// File: rtl/rb_axi_rd_master.sv
// Single-beat AXI4 read engine.
// On start it zero-extends the client address to the physical width, offers it on AR until accepted,
// then waits for one R beat and reports completion with the owner index.
// Assumes the slave returns exactly one beat per address.
module rb_axi_rd_master #(
    parameter int CAW = 32,
    parameter int PAW = 48,
    parameter int DW  = 32,
    parameter int IW  = 1,
    localparam int EXT_W = PAW - CAW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [CAW-1:0] start_addr,
    input  logic [IW-1:0]  start_idx,
    output logic           idle,
    output logic           ar_valid,
    input  logic           ar_ready,
    output logic [PAW-1:0] ar_addr,
    output logic [7:0]     ar_len,
    output logic [2:0]     ar_size,
    input  logic           r_valid,
    output logic           r_ready,
    output logic           cmp_valid,
    output logic [IW-1:0]  cmp_idx
);
    import dual_rd_bridge_pkg::*;

    rd_state_t     state;
    logic [IW-1:0] owner;

    // Transaction sequencer: idle, address phase, data phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= RD_IDLE;
            ar_valid <= 1'b0;
            ar_addr  <= '0;
            owner    <= '0;
        end else begin
            case (state)
                RD_IDLE: begin
                    if (start) begin
                        ar_addr  <= {{EXT_W{1'b0}}, start_addr};
                        owner    <= start_idx;
                        ar_valid <= 1'b1;
                        state    <= RD_ADDR;
                    end
                end
                RD_ADDR: begin
                    if (ar_ready) begin
                        ar_valid <= 1'b0;
                        state    <= RD_DATA;
                    end
                end
                RD_DATA: begin
                    if (r_valid)
                        state <= RD_IDLE;
                end
                default: state <= RD_IDLE;
            endcase
        end
    end

    assign idle      = (state == RD_IDLE);
    assign r_ready   = (state == RD_DATA);
    assign cmp_valid = r_ready && r_valid;
    assign cmp_idx   = owner;
    assign ar_len    = 8'd0;
    assign ar_size   = 3'($clog2(DW / 8));
endmodule

// File: rtl/rb_rsp_hold.sv
// Response holder for one client.
// Registers the returned word and a one-cycle acknowledge when the completion belongs to this port.
// The data is held between completions.
module rb_rsp_hold #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hit,
    input  logic [DW-1:0] data,
    output logic          ack,
    output logic [DW-1:0] rdata
);
    // Acknowledge pulse: high for the cycle after a matching completion.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ack <= 1'b0;
        else
            ack <= hit;
    end

    // Data register: loaded only on this port's completion.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else if (hit)
            rdata <= data;
    end
endmodule

// File: rtl/dual_rd_bridge.sv
// Top level of the dual-requester read bridge. Port 0 is the core client, port 1 the controller client.
// Request latches feed a fixed-priority arbiter, and the arbiter starts the single-beat AXI4 read engine.
// Completions are steered to the owning client's response holder.
module dual_rd_bridge
    import dual_rd_bridge_pkg::*;
#(
    parameter int CAW = CLIENT_AW,
    parameter int PAW = PHYS_AW,
    parameter int DW  = DATA_W,
    localparam int NP = NUM_PORTS,
    localparam int IW = $clog2(NP)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           core_req,
    input  logic [CAW-1:0] core_addr,
    output logic           core_ack,
    output logic [DW-1:0]  core_rdata,
    input  logic           ctl_req,
    input  logic [CAW-1:0] ctl_addr,
    output logic           ctl_ack,
    output logic [DW-1:0]  ctl_rdata,
    output logic           ar_valid,
    input  logic           ar_ready,
    output logic [PAW-1:0] ar_addr,
    output logic [7:0]     ar_len,
    output logic [2:0]     ar_size,
    input  logic           r_valid,
    output logic           r_ready,
    input  logic [DW-1:0]  r_data
);
    logic [NP-1:0]          req_v;
    logic [NP-1:0][CAW-1:0] addr_v;
    logic [NP-1:0]          pend_v;
    logic [NP-1:0][CAW-1:0] paddr_v;
    logic [NP-1:0]          gnt_v;
    logic [NP-1:0]          ack_v;
    logic [NP-1:0][DW-1:0]  rdata_v;
    logic                   gnt_valid;
    logic [IW-1:0]          gnt_idx;
    logic [CAW-1:0]         shared_addr;
    logic                   eng_idle;
    logic                   cmp_valid;
    logic [IW-1:0]          cmp_idx;

    assign req_v  = {ctl_req, core_req};
    assign addr_v = {ctl_addr, core_addr};

    // Per-client request capture and response holding.
    generate
        for (genvar p = 0; p < NP; p++) begin : g_port
            rb_req_latch #(.AW(CAW)) u_latch (
                .clk    (clk),
                .rst_n  (rst_n),
                .req    (req_v[p]),
                .addr   (addr_v[p]),
                .take   (gnt_v[p]),
                .pend   (pend_v[p]),
                .addr_q (paddr_v[p])
            );

            rb_rsp_hold #(.DW(DW)) u_hold (
                .clk   (clk),
                .rst_n (rst_n),
                .hit   (cmp_valid && (cmp_idx == IW'(p))),
                .data  (r_data),
                .ack   (ack_v[p]),
                .rdata (rdata_v[p])
            );
        end
    endgenerate

    rb_arbiter #(.N(NP), .AW(CAW)) u_arb (
        .pend      (pend_v),
        .addrs     (paddr_v),
        .idle      (eng_idle),
        .gnt_valid (gnt_valid),
        .gnt_idx   (gnt_idx),
        .gnt_vec   (gnt_v),
        .gnt_addr  (shared_addr)
    );

    rb_axi_rd_master #(.CAW(CAW), .PAW(PAW), .DW(DW), .IW(IW)) u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (gnt_valid),
        .start_addr (shared_addr),
        .start_idx  (gnt_idx),
        .idle       (eng_idle),
        .ar_valid   (ar_valid),
        .ar_ready   (ar_ready),
        .ar_addr    (ar_addr),
        .ar_len     (ar_len),
        .ar_size    (ar_size),
        .r_valid    (r_valid),
        .r_ready    (r_ready),
        .cmp_valid  (cmp_valid),
        .cmp_idx    (cmp_idx)
    );

    assign core_ack   = ack_v[0];
    assign ctl_ack    = ack_v[1];
    assign core_rdata = rdata_v[0];
    assign ctl_rdata  = rdata_v[1];
endmodule

// File: rtl/dual_rd_bridge_chk.sv
// Property checker for the dual-requester read bridge, attached with the bind at the end of this file.
// Assumes the bus slave raises r_valid only while r_ready is high.
module dual_rd_bridge_chk #(
    parameter int PAW = 48,
    parameter int DW  = 32
) (
    input logic           clk,
    input logic           rst_n,
    input logic           core_ack,
    input logic           ctl_ack,
    input logic [DW-1:0]  core_rdata,
    input logic [DW-1:0]  ctl_rdata,
    input logic           ar_valid,
    input logic           ar_ready,
    input logic [PAW-1:0] ar_addr,
    input logic           r_valid,
    input logic           r_ready
);
    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ar_valid |-> (ar_addr[PAW-1:32] == '0)); // R2

    AST_AR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ar_valid && !ar_ready) |=> (ar_valid && $stable(ar_addr))); // R6

    AST_AR_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (ar_valid && ar_ready) |=> (!ar_valid && r_ready)); // R8

    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        !(ar_valid && r_ready)); // R8

    AST_ACK_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(core_ack && ctl_ack)); // R9

    AST_CORE_ACK_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        core_ack |-> $past(r_valid && r_ready)); // R9

    AST_CTL_ACK_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_ack |-> $past(r_valid && r_ready)); // R9

    AST_CORE_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !core_ack |-> $stable(core_rdata)); // R10

    AST_CTL_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_ack |-> $stable(ctl_rdata)); // R10
endmodule

bind dual_rd_bridge dual_rd_bridge_chk #(.PAW(PAW), .DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .core_ack   (core_ack),
    .ctl_ack    (ctl_ack),
    .core_rdata (core_rdata),
    .ctl_rdata  (ctl_rdata),
    .ar_valid   (ar_valid),
    .ar_ready   (ar_ready),
    .ar_addr    (ar_addr),
    .r_valid    (r_valid),
    .r_ready    (r_ready)
);

// File: tb/dual_rd_bridge_test.sv
`timescale 1ns/1ps
// Bench for the dual-requester read bridge. A behavioural model of the expected port values is
// advanced once per cycle and compared with the design at every falling edge.
module dual_rd_bridge_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        core_req = 1'b0, ctl_req = 1'b0;
    logic [31:0] core_addr = '0, ctl_addr = '0;
    logic        core_ack, ctl_ack;
    logic [31:0] core_rdata, ctl_rdata;
    logic        ar_valid, ar_ready = 1'b0;
    logic [47:0] ar_addr;
    logic [7:0]  ar_len;
    logic [2:0]  ar_size;
    logic        r_valid = 1'b0, r_ready;
    logic [31:0] r_data = '0;

    dual_rd_bridge uut (
        .clk(clk), .rst_n(rst_n),
        .core_req(core_req), .core_addr(core_addr), .core_ack(core_ack), .core_rdata(core_rdata),
        .ctl_req(ctl_req), .ctl_addr(ctl_addr), .ctl_ack(ctl_ack), .ctl_rdata(ctl_rdata),
        .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_addr(ar_addr), .ar_len(ar_len),
        .ar_size(ar_size), .r_valid(r_valid), .r_ready(r_ready), .r_data(r_data)
    );

    always #5 clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;

    // Stimulus controls
    logic        drv_rst = 1'b0;
    logic [1:0]  want = '0;
    logic [31:0] want_addr [2];
    int          cfg_ar = 0, cfg_r = 0;
    bit          cfg_rand = 0;
    bit          busy [2];

    // Behavioural model state
    int          m_state = 0;          // 0 idle, 1 address offered, 2 awaiting data
    bit          m_pend [2];
    logic [31:0] m_paddr [2];
    logic [47:0] m_araddr = '0;
    bit          m_ack [2];
    logic [31:0] m_rd [2];
    int          owners [$];
    int          ar_left = 0, r_left = 0;

    function automatic logic [31:0] mem_word(logic [47:0] a);
        return {a[15:0], a[31:16]} ^ 32'h5A3C_96E1;
    endfunction

    task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s at %0t: actual 0x%0h expected 0x%0h", tag, $time, act, exp);
        end
    endtask

    task automatic model_reset();
        m_state = 0; m_araddr = '0; owners.delete();
        for (int p = 0; p < 2; p++) begin
            m_pend[p] = 0; m_paddr[p] = '0; m_ack[p] = 0; m_rd[p] = '0; busy[p] = 0;
        end
    endtask

    // One clock cycle: compare, drive the next inputs, advance the model across the coming edge.
    task automatic step();
        logic [1:0] rq;
        @(negedge clk);
        chk(ar_valid == (m_state == 1), "R3/R4/R5/R6 ar_valid", 64'(ar_valid), 64'(m_state == 1));
        chk(ar_addr == m_araddr, "R2/R4/R6 ar_addr", 64'(ar_addr), 64'(m_araddr));
        chk(!ar_valid || (ar_len == 8'd0 && ar_size == 3'b010), "R7 ar_len/ar_size",
            64'({ar_len, ar_size}), 64'({8'd0, 3'b010}));
        chk(r_ready == (m_state == 2), "R8 r_ready", 64'(r_ready), 64'(m_state == 2));
        chk(core_ack == m_ack[0], "R9 core_ack", 64'(core_ack), 64'(m_ack[0]));
        chk(ctl_ack == m_ack[1], "R9 ctl_ack", 64'(ctl_ack), 64'(m_ack[1]));
        chk(core_rdata == m_rd[0], "R10 core_rdata", 64'(core_rdata), 64'(m_rd[0]));
        chk(ctl_rdata == m_rd[1], "R10 ctl_rdata", 64'(ctl_rdata), 64'(m_rd[1]));

        rq = drv_rst ? want : 2'b00;
        rst_n     = drv_rst;
        core_req  = rq[0];
        ctl_req   = rq[1];
        core_addr = rq[0] ? want_addr[0] : $urandom;
        ctl_addr  = rq[1] ? want_addr[1] : $urandom;
        if (m_state == 1) begin
            ar_ready = (ar_left == 0);
            if (ar_left > 0) ar_left--;
        end else begin
            ar_ready = 1'($urandom);
        end
        if (m_state == 2) begin
            r_valid = (r_left == 0);
            r_data  = (r_left == 0) ? mem_word(m_araddr) : $urandom;
            if (r_left > 0) r_left--;
        end else begin
            r_valid = 1'b0;
            r_data  = $urandom;
        end

        if (!drv_rst) begin
            model_reset();
        end else begin
            m_ack[0] = 0; m_ack[1] = 0;
            case (m_state)
                0: begin
                    for (int p = 0; p < 2; p++) begin
                        if (m_state == 0 && m_pend[p]) begin
                            m_araddr = {16'h0000, m_paddr[p]};
                            m_pend[p] = 0;
                            owners.push_back(p);
                            m_state = 1;
                            ar_left = cfg_rand ? int'($urandom % 4) : cfg_ar;
                        end
                    end
                end
                1: if (ar_ready) begin
                    m_state = 2;
                    r_left = cfg_rand ? int'($urandom % 5) : cfg_r;
                end
                default: if (r_valid) begin
                    int o;
                    o = owners.pop_front();
                    m_ack[o] = 1;
                    m_rd[o] = r_data;
                    busy[o] = 0;
                    m_state = 0;
                end
            endcase
            for (int p = 0; p < 2; p++) begin
                if (rq[p]) begin
                    m_pend[p] = 1; m_paddr[p] = want_addr[p]; busy[p] = 1;
                end
            end
        end
        want = '0;
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(1_500_000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        model_reset();
        want_addr[0] = '0; want_addr[1] = '0;
        repeat (4) step();
        // R1: reset state at the ports
        chk(!ar_valid && !r_ready && !core_ack && !ctl_ack, "R1 reset outputs",
            64'({ar_valid, r_ready, core_ack, ctl_ack}), 64'd0);
        chk(ar_addr == '0 && core_rdata == '0 && ctl_rdata == '0, "R1 reset data",
            64'(ar_addr), 64'd0);
        drv_rst = 1'b1;
        repeat (3) step();
        chk(!ar_valid, "R1 no read without request", 64'(ar_valid), 64'd0);

        // R3/R2: core read crossing bit 31
        cfg_ar = 0; cfg_r = 2;
        want = 2'b01; want_addr[0] = 32'h8000_0000; step();
        repeat (10) step();
        // R5/R2: controller read with core idle
        want = 2'b10; want_addr[1] = 32'h8000_0000; step();
        repeat (10) step();
        // R4/R6: simultaneous requests, slow address acceptance
        cfg_ar = 3; cfg_r = 1;
        want = 2'b11; want_addr[0] = 32'h1234_5678; want_addr[1] = 32'hFFFF_FFFF; step();
        repeat (25) step();
        // R1: reset in the middle of an address phase
        cfg_ar = 6;
        want = 2'b01; want_addr[0] = 32'hDEAD_BEEF; step();
        repeat (3) step();
        drv_rst = 1'b0; step(); step();
        chk(!ar_valid && !r_ready, "R1 mid-read reset", 64'({ar_valid, r_ready}), 64'd0);
        drv_rst = 1'b1;
        repeat (5) step();
        chk(!ar_valid, "R1 pending cleared by reset", 64'(ar_valid), 64'd0);

        // Random traffic on both ports with random slave delays
        cfg_rand = 1;
        for (int c = 0; c < 4000; c++) begin
            for (int p = 0; p < 2; p++) begin
                if (!busy[p] && ($urandom % 6 == 0)) begin
                    want[p] = 1'b1;
                    want_addr[p] = ($urandom % 2) ? ($urandom | 32'h8000_0000) : $urandom;
                end
            end
            step();
        end
        repeat (40) step();

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule